// File: doc/BRIEF.md
# Low-Voltage Detector Status and Control Register

This block is the 8-bit status and control register that sits between an external low-voltage comparator and the rest of the chip. It takes the comparator's raw detect level, which is asynchronous, and passes it through a synchronizer. While detection is enabled, it latches a sticky detect flag. Software can see and change the register through a plain write strobe with write data and a read-data bus. The read-data bus always shows the current register image.

The flag raises an interrupt request when the interrupt enable is set. It raises a system reset request when the reset enable and the detector enable are both set. Software clears the flag by writing 1 to a separate acknowledge bit, which always reads back as 0.

Three configuration bits (reset enable, stop-mode keep-alive and detector enable) accept only the first register write after reset. Each bit has a hidden lock that the first write sets, whatever value that write carries. The detector enable, the stop-mode keep-alive and the bandgap buffer enable also drive plain control pins toward the analog side.

The block has no streamed data, so every pin is a plain level. The bus has no back-pressure: a write completes in the clock cycle in which its strobe is high.

Top module: `lvd_ctl_top`

## Requirements
- R1: Bit 7 (flag) is set at the clock edge after the synchronized detect level is high, counted DET_SYNC_STAGES+1 edges after the raw input rises, and only while bit 2 (detector enable) is 1. It stays set until it is acknowledged.
- R2: A write with data bit 6 = 1 clears the flag. Bit 6 always reads 0.
- R3: irq_o is 1 exactly when the flag and bit 5 (interrupt enable, read/write) are both 1.
- R4: reset_req_o is 1 exactly when the flag, bit 4 (reset enable) and bit 2 (detector enable) are all 1.
- R5: Bits 4, 3 and 2 take the value of the first write after reset only. That write locks them whatever it carries, and later writes leave them unchanged.
- R6: Bit 1 always reads 0, even after a 1 is written to it. Bit 0 (bandgap buffer enable) is read/write.
- R7: After reset the register reads 0x1C, and irq_o and reset_req_o are 0.
- R8: det_en_o, stop_en_o and bgbuf_en_o follow bits 2, 3 and 0.
- R9: When a synchronized detect (with the detector enabled) and an acknowledge occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_detect_i | input | 1 | Asynchronous low-voltage level from the comparator |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Current register image |
| irq_o | output | 1 | Interrupt request |
| reset_req_o | output | 1 | System reset request |
| det_en_o | output | 1 | Detector enable to the comparator |
| stop_en_o | output | 1 | Keep the detector running in stop mode |
| bgbuf_en_o | output | 1 | Bandgap buffer enable |

## Verification
The hardest situations to reach are the ones that depend on the single unlocked write. One is a flag that was set under the default enables and is then left standing when that first write turns the detector off. The other is a collision between a detect and an acknowledge in one cycle. The bench reaches the first by raising the detect level right after reset and before any write, then issuing the first write with only the reset enable set; the reset request must then be gated low. It reaches the second by holding the raw level high past the synchronizer latency and writing the acknowledge while the level is still high.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int unsigned REG_W = 8;
  // bit positions: observable through the register image
  localparam int unsigned B_FLAG  = 7;
  localparam int unsigned B_ACK   = 6;
  localparam int unsigned B_IRQEN = 5;
  localparam int unsigned B_RSTEN = 4;
  localparam int unsigned B_STOP  = 3;
  localparam int unsigned B_DETEN = 2;
  localparam int unsigned B_RSVD  = 1;
  localparam int unsigned B_BGBUF = 0;
  localparam int unsigned N_ONCE  = 3;
  // ordered list of write-once bit positions
  localparam int unsigned ONCE_POS [N_ONCE] = '{B_RSTEN, B_STOP, B_DETEN};
  localparam logic [N_ONCE-1:0] ONCE_RST = '1;
  localparam logic [REG_W-1:0] REG_RST = 8'h1C;
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2+((STAGES>1)?0:1):0], d_i} ;
      end
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lvd_once_bit.sv
module lvd_once_bit #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic d_i,
  output logic q_o,
  output logic lock_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o    <= RST_VAL;
      lock_o <= 1'b0;
    end else if (wr_i && !lock_o) begin
      q_o    <= d_i;
      lock_o <= 1'b1;
    end
  end
endmodule

// File: rtl/lvd_flag.sv
module lvd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic det_i,
  input  logic enable_i,
  input  logic ack_i,
  output logic flag_o
);
  logic set_w;
  assign set_w = det_i && enable_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_w) flag_o <= 1'b1;   // set wins over acknowledge
    else if (ack_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/lvd_ctl_top.sv
module lvd_ctl_top
  import lvd_pkg::*;
#(
  parameter int unsigned DET_SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_detect_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o,
  output logic             reset_req_o,
  output logic             det_en_o,
  output logic             stop_en_o,
  output logic             bgbuf_en_o
);
  logic              det_sync;
  logic              flag_q;
  logic              irq_en_q;
  logic              bgbuf_q;
  logic [N_ONCE-1:0] once_q;
  logic [N_ONCE-1:0] once_lock;
  logic              ack_w;

  lvd_sync #(.STAGES(DET_SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_detect_i), .q_o(det_sync)
  );

  assign ack_w = wr_en_i && wr_data_i[B_ACK];

  lvd_flag u_flag (
    .clk(clk), .rst_n(rst_n), .det_i(det_sync), .enable_i(det_en_o),
    .ack_i(ack_w), .flag_o(flag_q)
  );

  for (genvar gi = 0; gi < N_ONCE; gi++) begin : g_once
    lvd_once_bit #(.RST_VAL(ONCE_RST[gi])) u_bit (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_en_i),
      .d_i(wr_data_i[ONCE_POS[gi]]), .q_o(once_q[gi]), .lock_o(once_lock[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= REG_RST[B_IRQEN];
      bgbuf_q  <= REG_RST[B_BGBUF];
    end else if (wr_en_i) begin
      irq_en_q <= wr_data_i[B_IRQEN];
      bgbuf_q  <= wr_data_i[B_BGBUF];
    end
  end

  // once_q order follows ONCE_POS: reset enable, stop, detector enable
  assign det_en_o   = once_q[2];
  assign stop_en_o  = once_q[1];
  assign bgbuf_en_o = bgbuf_q;

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[B_FLAG]  = flag_q;
    rd_data_o[B_IRQEN] = irq_en_q;
    rd_data_o[B_BGBUF] = bgbuf_q;
    for (int i = 0; i < N_ONCE; i++) rd_data_o[ONCE_POS[i]] = once_q[i];
  end

  assign irq_o       = flag_q && irq_en_q;
  assign reset_req_o = flag_q && once_q[0] && det_en_o;
endmodule

// File: rtl/lvd_ctl_chk.sv
module lvd_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       det_s,
  input logic [2:0] locked,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd,
  input logic       irq,
  input logic       rreq,
  input logic       det_en
);
  // R1
  flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> !$rose(rd[7]));
  // R2
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[6] && !(det_s && det_en)) |=> !rd[7]);
  // R3
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd[7] && rd[5]));
  // R4
  rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rreq |-> (rd[7] && rd[4] && rd[2]));
  // R5
  once_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&locked) |=> $stable(rd[4:2]));
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_s && det_en) |=> rd[7]);
endmodule

bind lvd_ctl_top lvd_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .det_s(det_sync), .locked(once_lock),
  .wr_en(wr_en_i), .wr_data(wr_data_i), .rd(rd_data_o), .irq(irq_o),
  .rreq(reset_req_o), .det_en(det_en_o)
);

// File: tb/test_lvd_ctl_top.sv
module test_lvd_ctl_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd;
  logic       irq, rreq, det_en, stop_en, bgbuf;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvd_ctl_top #(.DET_SYNC_STAGES(SYNC)) i_lvd_ctl_top (
    .clk(clk), .rst_n(rst_n), .raw_detect_i(raw), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd), .irq_o(irq), .reset_req_o(rreq),
    .det_en_o(det_en), .stop_en_o(stop_en), .bgbuf_en_o(bgbuf)
  );

  typedef struct {
    logic [7:0] rd;
    logic       irq;
    logic       rst;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  event smp_ev;

  // monitor: pops the expected item and compares against the ports
  initial begin
    forever begin
      @(smp_ev);
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (rd !== e.rd) begin
          fails++;
          $display("FAIL %s rd_data actual=%h expected=%h", e.tag, rd, e.rd);
        end
        checks++;
        if (irq !== e.irq || rreq !== e.rst) begin
          fails++;
          $display("FAIL %s irq/reset actual=%b%b expected=%b%b", e.tag, irq, rreq, e.irq, e.rst);
        end
        checks++;
        // R8: control pins mirror bits 3,2,0
        if ({stop_en, det_en, bgbuf} !== {e.rd[3], e.rd[2], e.rd[0]}) begin
          fails++;
          $display("FAIL R8 %s pins actual=%b expected=%b", e.tag,
                   {stop_en, det_en, bgbuf}, {e.rd[3], e.rd[2], e.rd[0]});
        end
      end
    end
  end

  task automatic expect_st(input logic [7:0] r, input logic i, input logic s, input string tag);
    exp_t e;
    e.rd = r; e.irq = i; e.rst = s; e.tag = tag;
    sb_q.push_back(e);
    #1;
    -> smp_ev;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; raw = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic det_rise();
    @(negedge clk);
    raw = 1'b1;
    repeat (SYNC + 1) @(negedge clk);
  endtask

  task automatic det_fall();
    @(negedge clk);
    raw = 1'b0;
    repeat (SYNC + 2) @(negedge clk);
  endtask

  initial begin
    do_reset();
    expect_st(8'h1C, 0, 0, "R7 reset image");
    det_rise();
    expect_st(8'h9C, 0, 1, "R1 R4 flag set, reset request");
    det_fall();
    expect_st(8'h9C, 0, 1, "R1 flag sticky");
    bus_wr(8'h5C);
    expect_st(8'h1C, 0, 0, "R2 ack clears, ack reads 0");
    bus_wr(8'h23);
    expect_st(8'h3D, 0, 0, "R5 R6 locked bits kept, bit1 reads 0, bit0 set");
    det_rise();
    expect_st(8'hBD, 1, 1, "R3 irq with enable");
    bus_wr(8'h7D);
    expect_st(8'hBD, 1, 1, "R9 detect beats ack");
    det_fall();
    bus_wr(8'h7D);
    expect_st(8'h3D, 0, 0, "R2 ack after level drops");
    bus_wr(8'h20);
    expect_st(8'h3C, 0, 0, "R6 bit0 cleared");
    bus_wr(8'h00);
    expect_st(8'h1C, 0, 0, "R5 locked against zeros");
    det_rise();
    expect_st(8'h9C, 0, 1, "R3 irq gated off");
    det_fall();
    bus_wr(8'h40);
    expect_st(8'h1C, 0, 0, "R2 ack");

    do_reset();
    expect_st(8'h1C, 0, 0, "R7 second reset");
    bus_wr(8'h00);
    expect_st(8'h00, 0, 0, "R5 first write of zeros");
    bus_wr(8'h1C);
    expect_st(8'h00, 0, 0, "R5 later write ignored");
    det_rise();
    expect_st(8'h00, 0, 0, "R1 detector disabled, no flag");
    det_fall();

    do_reset();
    det_rise();
    det_fall();
    bus_wr(8'h10);
    expect_st(8'h90, 0, 0, "R4 reset request gated by detector enable");
    bus_wr(8'h30);
    expect_st(8'hB0, 1, 0, "R3 irq independent of detector enable");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule